// File: doc/BRIEF.md
# Set-Associative Tag Controller with Next-Line Prefetch

This block models the tag side of a data cache. Each request is either a load or a store and carries a byte address. The block answers one cycle later with a hit or a miss. For every set it keeps valid bits, tags and true least-recently-used ordering. No data is stored. The line size and the total capacity are parameters; the defaults are 32-byte lines and 16 KB. The number of ways can be 2, 4, 8 or 16, and the set count follows from the capacity.

Two mode inputs change how the controller behaves. The first selects whether a store that misses allocates its line. The second selects the prefetch policy: no prefetch, next-line prefetch on every access, or next-line prefetch only on a demand miss. A prefetch needs one extra lookup cycle, during which the controller deasserts ready. The prefetched line is installed internally and takes part in the same LRU ordering. Two counters track accepted requests and demand hits.

Top module: `set_assoc_tag_ctrl`

## Requirements
- R1: The line number is the address with its low log2(LINE_BYTES) offset bits removed. The low log2(SETS) bits of the line number select the set, where SETS = CACHE_BYTES/LINE_BYTES/WAYS, and the remaining bits form the tag. A request hits exactly when a valid way of its set holds its tag.
- R2: A line that must be installed goes to the lowest-numbered invalid way of its set. When every way of the set is valid, it replaces the least recently used way. A demand hit, a demand fill and a prefetch install each make their way the most recently used.
- R3: When no_wr_alloc is 0, a load miss installs its line and a store miss installs its line.
- R4: When no_wr_alloc is 1, a store miss reports a miss, changes no valid bit, tag or LRU state, and starts no prefetch. A store hit updates LRU the same way a load hit does.
- R5: pf_mode encoding: 0 and 3 mean no prefetch, 1 means prefetch on every access, 2 means prefetch on a miss. With pf_mode 1, every accepted request (except an R4 store miss) then looks up line X+1, where X is the request's line. If line X+1 is absent, it is installed under R2.
- R6: With pf_mode 2, the lookup of line X+1 happens only when the demand access to line X missed, and not after an R4 store miss.
- R7: A prefetch lookup that finds line X+1 already present changes no state.
- R8: access_count increments by one for each accepted request. hit_count increments by one for each demand hit. Prefetch lookups change neither counter.
- R9: resp_valid is high for exactly one cycle, the cycle after a request is accepted, and resp_hit carries that request's result. req_ready is low for exactly the one cycle after an accept that scheduled a prefetch, and high otherwise.
- R10: A synchronous reset (rst high at a clock edge) clears every valid bit, all LRU state and both counters. It leaves req_ready high and resp_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The controller can accept a request this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address of the request |
| no_wr_alloc | input | 1 | 1 means a store miss does not allocate |
| pf_mode | input | 2 | Prefetch policy select (see R5) |
| resp_valid | output | 1 | Result of the previously accepted request is available |
| resp_hit | output | 1 | 1 when that request hit |
| access_count | output | CNT_W | Number of accepted requests |
| hit_count | output | CNT_W | Number of demand hits |

## Verification
The hardest case to reach from the ports is a prefetch that either lands on a line already resident or evicts a line that a demand access touched only moments earlier. In both cases, the ordering that is visible later depends on a step that produces no response of its own. The bench reaches these cases with a deliberately small configuration: 4 ways and 4 sets, driven by a pool of 24 lines. Random accesses are mixed with runs of consecutive lines, so next-line prefetches keep colliding with resident lines and with full sets. Every combination of allocation mode and prefetch mode is swept. Each response and each stall cycle is compared against a timestamp-based reference computed in the bench.

// File: rtl/set_assoc_tag_ctrl.sv
module set_assoc_tag_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              no_wr_alloc,
  input  logic [1:0]        pf_mode,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int LINES = CACHE_BYTES / LINE_BYTES;
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LN_W - SET_W;
  localparam int KEY_W = SET_W + AGE_W;

  logic [LINES-1:0] valid;
  logic [TAG_W-1:0] tags [LINES];
  logic [AGE_W-1:0] ages [LINES];

  logic             in_pf;
  logic [LN_W-1:0]  pf_line;

  logic [LN_W-1:0]  look_line;
  logic [SET_W-1:0] look_set;
  logic [TAG_W-1:0] look_tag;

  logic             hit_any, free_any;
  logic [AGE_W-1:0] hit_way, free_way, lru_way, tgt_way, old_age;

  logic accept, nwa_miss, dem_fill, pf_go, touch;

  assign req_ready = !in_pf;
  assign accept    = req_valid && req_ready;
  assign look_line = in_pf ? pf_line : req_addr[ADDR_W-1:OFF_W];
  assign look_set  = look_line[SET_W-1:0];
  assign look_tag  = look_line[LN_W-1:SET_W];

  always_comb begin
    hit_any  = 1'b0;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    lru_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[{look_set, AGE_W'(w)}]) begin
        free_any = 1'b1;
        free_way = AGE_W'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (valid[{look_set, AGE_W'(w)}] && tags[{look_set, AGE_W'(w)}] == look_tag) begin
        hit_any = 1'b1;
        hit_way = AGE_W'(w);
      end
      if (ages[{look_set, AGE_W'(w)}] == {AGE_W{1'b1}})
        lru_way = AGE_W'(w);
    end
  end

  assign tgt_way  = hit_any ? hit_way : (free_any ? free_way : lru_way);
  assign old_age  = hit_any ? ages[{look_set, hit_way}] : {AGE_W{1'b1}};
  assign nwa_miss = req_store && no_wr_alloc && !hit_any;
  assign dem_fill = !hit_any && !nwa_miss;
  assign pf_go    = accept && !nwa_miss &&
                    (pf_mode == 2'd1 || (pf_mode == 2'd2 && !hit_any));
  assign touch    = accept ? (hit_any || dem_fill) : (in_pf && !hit_any);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid        <= '0;
      in_pf        <= 1'b0;
      pf_line      <= '0;
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      access_count <= '0;
      hit_count    <= '0;
      for (int i = 0; i < LINES; i++) ages[i] <= '0;
    end else begin
      resp_valid <= accept;
      in_pf      <= pf_go;
      if (pf_go) pf_line <= look_line + LN_W'(1);
      if (accept) begin
        resp_hit     <= hit_any;
        access_count <= access_count + CNT_W'(1);
        if (hit_any) hit_count <= hit_count + CNT_W'(1);
      end
      if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (AGE_W'(w) == tgt_way) begin
            valid[{look_set, AGE_W'(w)}] <= 1'b1;
            ages[{look_set, AGE_W'(w)}]  <= '0;
          end else if (valid[{look_set, AGE_W'(w)}] &&
                       ages[{look_set, AGE_W'(w)}] < old_age) begin
            ages[{look_set, AGE_W'(w)}] <= ages[{look_set, AGE_W'(w)}] + AGE_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (touch && !hit_any) tags[{look_set, tgt_way}] <= look_tag;
  end

  p_resp_follows_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> resp_valid);
  p_no_resp_without_accept_r9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !resp_valid);
  p_access_count_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> access_count == $past(access_count) + CNT_W'(1));
  p_idle_counters_r8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(access_count) && $stable(hit_count));
  p_no_pf_mode_r5: assert property (@(posedge clk) disable iff (rst)
    accept && (pf_mode == 2'd0 || pf_mode == 2'd3) |=> req_ready);
  p_miss_only_r6: assert property (@(posedge clk) disable iff (rst)
    accept && pf_mode == 2'd2 && hit_any |=> req_ready);
  p_nwa_store_miss_r4: assert property (@(posedge clk) disable iff (rst)
    accept && req_store && no_wr_alloc && !hit_any |=> req_ready && !resp_hit);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> access_count == '0 && hit_count == '0 && !resp_valid);
endmodule

// File: tb/sim_set_assoc_tag_ctrl.sv
`timescale 1ns/1ps
module sim_set_assoc_tag_ctrl;
  localparam int NW = 4;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [31:0] req_addr = '0;
  logic        no_wr_alloc = 1'b0;
  logic [1:0]  pf_mode = 2'd0;
  logic        resp_valid, resp_hit;
  logic [31:0] access_count, hit_count;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  set_assoc_tag_ctrl #(.ADDR_W(32), .CACHE_BYTES(512), .LINE_BYTES(32), .WAYS(NW), .CNT_W(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .no_wr_alloc(no_wr_alloc),
    .pf_mode(pf_mode), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .access_count(access_count), .hit_count(hit_count));

  bit mv [NS][NW];
  int mt [NS][NW];
  int ms [NS][NW];
  int tick, m_acc, m_hit;

  function automatic int m_find(int line);
    for (int w = 0; w < NW; w++)
      if (mv[line % NS][w] && mt[line % NS][w] == line / NS) return w;
    return -1;
  endfunction

  task automatic m_use(int s, int w);
    tick++;
    ms[s][w] = tick;
  endtask

  task automatic m_install(int line);
    int s = line % NS;
    int v = -1;
    for (int w = NW - 1; w >= 0; w--) if (!mv[s][w]) v = w;
    if (v < 0) begin
      v = 0;
      for (int w = 1; w < NW; w++) if (ms[s][w] < ms[s][v]) v = w;
    end
    mv[s][v] = 1'b1;
    mt[s][v] = line / NS;
    m_use(s, v);
  endtask

  task automatic m_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 1'b0; mt[s][w] = 0; ms[s][w] = 0;
      end
    tick = 0; m_acc = 0; m_hit = 0;
  endtask

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    check(resp_valid == 1'b0, "R10", "resp_valid after reset", resp_valid, 0);
    check(access_count == 0 && hit_count == 0, "R10", "counters after reset",
          access_count + hit_count, 0);
  endtask

  task automatic do_req(int line, bit st, string tags);
    int w;
    bit hit, pf;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_store = st;
    req_addr  = (line << 5) | (line % 32);
    w   = m_find(line);
    hit = (w >= 0);
    m_acc++;
    if (hit) begin
      m_hit++;
      m_use(line % NS, w);
    end else if (!(st && no_wr_alloc)) begin
      m_install(line);
    end
    pf = !(st && no_wr_alloc && !hit) && (pf_mode == 2'd1 || (pf_mode == 2'd2 && !hit));
    if (pf && m_find(line + 1) < 0) m_install(line + 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, "R9", "resp_valid after accept", resp_valid, 1);
    check(resp_hit == hit, tags, "hit result", resp_hit, hit);
    check(req_ready == !pf, "R9 R5 R6", "ready during prefetch cycle", req_ready, !pf);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int line;
    string tags;
    for (int nwa = 0; nwa < 2; nwa++) begin
      for (int pm = 0; pm < 4; pm++) begin
        no_wr_alloc = nwa[0];
        pf_mode = pm[1:0];
        do_reset();
        tags = nwa ? "R1 R2 R4" : "R1 R2 R3";
        if (pm == 1) tags = {tags, " R5 R7"};
        else if (pm == 2) tags = {tags, " R6 R7"};
        else tags = {tags, " R5"};
        line = 0;
        for (int i = 0; i < 250; i++) begin
          if (i % 4 != 3) line = $urandom_range(0, 23);
          else line = (line + 1) % 24;
          do_req(line, $urandom_range(0, 2) == 0, tags);
        end
        @(negedge clk);
        @(negedge clk);
        check(access_count == m_acc, "R8", "access_count", access_count, m_acc);
        check(hit_count == m_hit, "R8", "hit_count", hit_count, m_hit);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule